// File: doc/BRIEF.md
# Bit-Sliced Memory Data Path with Byte Parity

This block is one slice of the data path that sits between a 32-bit memory data bus and a 32-bit host data bus. Both buses carry one parity bit per byte. On a processor read, the slice loads memory data and parity into a holding register. That register only loads while an external latch strobe is high. The held value is then presented to the host side. A small host command code controls the host-side output enable. The enable is set by a read-drive code. It is dropped on the rising edge of the latch strobe when the command is the idle code.

On a write, host data is passed to the memory side, together with even parity generated for each byte. A separate write-direction input gates the memory-side output enable. On every capture the slice recomputes parity over the held bytes and flags any byte whose stored parity bit disagrees. A strap input is sampled while reset is held. It tells the slice whether it serves the upper or the lower 16-bit lanes of each 32-bit half of a 64-bit memory word. The slice reports this identity and the lane bases that follow from it.

The memory and host buses are bidirectional in the system. Here each one is split into an input, an output and an output enable, and the pad tristate buffers are built outside the slice.

Top module: `mem_slice_datapath`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `host_oe_o`, `mem_oe_o` and `perr_o` read 0, and `host_d_o` and `host_p_o` read 0.
- R2: At any clock edge where `latch_en_i` is 1, `mem_d_i` and `mem_p_i` are captured, and they appear on `host_d_o` and `host_p_o` just after that edge.
- R3: At a clock edge where `latch_en_i` is 0, `host_d_o` and `host_p_o` keep their previous values, whatever `mem_d_i` and `mem_p_i` carry.
- R4: A host command of 5'b00001 (read-drive) at a clock edge sets `host_oe_o` to 1 just after that edge.
- R5: A host command of 5'b00000 (idle) clears `host_oe_o` just after an edge only when `latch_en_i` is 1 at that edge and was 0 at the previous edge. With the idle code and no such rising strobe, `host_oe_o` does not change.
- R6: Every host command other than 5'b00000 and 5'b00001 leaves `host_oe_o` unchanged.
- R7: Just after an edge where `wr_en_i` is 1, `mem_d_o` equals the `host_d_i` sampled at that edge. Each `mem_p_o[i]` is then the XOR of byte i of that data (even parity), where bit 0 covers bits 7:0 and bit 3 covers bits 31:24.
- R8: `mem_oe_o` equals the `wr_en_i` sampled at the previous clock edge.
- R9: One edge after a capture, `perr_o[i]` is 1 exactly when the XOR of captured byte i differs from captured parity bit i. If there was no capture at the edge before, `perr_o` is 0.
- R10: `strap_hi_i` is sampled only while `rst` is high. With the strap at 1 the slice reports `slice_hi_o`=1 and lane bases 48 (upper) and 16 (lower). With the strap at 0 it reports 0, 32 and 0. Changes to the strap after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hi_i | input | 1 | Upper/lower slice strap, sampled during reset |
| host_cmd_i | input | 5 | Host command code |
| latch_en_i | input | 1 | Read capture strobe (clock enable) |
| wr_en_i | input | 1 | Memory write-direction enable |
| mem_d_i | input | 32 | Data arriving from memory |
| mem_p_i | input | 4 | Parity arriving from memory |
| host_d_i | input | 32 | Data arriving from host |
| mem_d_o | output | 32 | Data driven to memory |
| mem_p_o | output | 4 | Generated even parity driven to memory |
| mem_oe_o | output | 1 | Memory-side output enable |
| host_d_o | output | 32 | Captured data driven to host |
| host_p_o | output | 4 | Captured parity driven to host |
| host_oe_o | output | 1 | Host-side output enable |
| perr_o | output | 4 | Per-byte parity mismatch flags |
| slice_hi_o | output | 1 | Latched slice identity |
| lane_up_base_o | output | 6 | Base lane of the upper 16-bit group |
| lane_lo_base_o | output | 6 | Base lane of the lower 16-bit group |

## Verification
Captured data, the host enable, the memory data and parity, and the memory enable all change in the same cycle as the edge that samples their inputs. Each check therefore reads them one nanosecond after that edge. Parity flags come one edge later than the capture they describe. The bench therefore takes a second step after a capture before it reads them, and then steps once more to confirm that the flags return to zero. Stimulus is always applied one nanosecond after an edge, so every input is stable for almost a full cycle before it is sampled.

// File: rtl/slice_dp_pkg.sv
package slice_dp_pkg;
  localparam int CMD_W = 5;
  localparam logic [CMD_W-1:0] HCMD_IDLE  = 5'b00000;
  localparam logic [CMD_W-1:0] HCMD_RDDRV = 5'b00001;

  typedef enum logic [1:0] {
    OE_HOLD  = 2'd0,
    OE_SET   = 2'd1,
    OE_CLEAR = 2'd2
  } oe_action_e;
endpackage

// File: rtl/slice_par_gen.sv
module slice_par_gen #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [NB-1:0]     par_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign par_o[b] = ^data_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/slice_rd_capture.sv
module slice_rd_capture #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_en_i,
  input  logic [DATA_W-1:0] mem_d_i,
  input  logic [NB-1:0]     mem_p_i,
  output logic [DATA_W-1:0] cap_d_o,
  output logic [NB-1:0]     cap_p_o,
  output logic [NB-1:0]     perr_o
);
  logic [DATA_W-1:0] cap_d;
  logic [NB-1:0]     cap_p;
  logic              cap_vld;
  logic [NB-1:0]     recomputed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_d   <= '0;
      cap_p   <= '0;
      cap_vld <= 1'b0;
    end else begin
      cap_vld <= latch_en_i;
      if (latch_en_i) begin
        cap_d <= mem_d_i;
        cap_p <= mem_p_i;
      end
    end
  end

  slice_par_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk_par (
    .data_i (cap_d),
    .par_o  (recomputed)
  );

  always_ff @(posedge clk) begin
    if (rst)          perr_o <= '0;
    else if (cap_vld) perr_o <= recomputed ^ cap_p;
    else              perr_o <= '0;
  end

  assign cap_d_o = cap_d;
  assign cap_p_o = cap_p;
endmodule

// File: rtl/slice_host_oe.sv
module slice_host_oe
  import slice_dp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_en_i,
  input  logic [CMD_W-1:0] host_cmd_i,
  output logic             host_oe_o
);
  logic       le_q;
  logic       le_rise;
  oe_action_e act;

  assign le_rise = latch_en_i & ~le_q;

  always_comb begin
    act = OE_HOLD;
    if (host_cmd_i == HCMD_RDDRV)                act = OE_SET;
    else if (host_cmd_i == HCMD_IDLE && le_rise) act = OE_CLEAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      le_q      <= 1'b0;
      host_oe_o <= 1'b0;
    end else begin
      le_q <= latch_en_i;
      case (act)
        OE_SET:   host_oe_o <= 1'b1;
        OE_CLEAR: host_oe_o <= 1'b0;
        default:  host_oe_o <= host_oe_o;
      endcase
    end
  end
endmodule

// File: rtl/slice_wr_path.sv
module slice_wr_path #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] host_d_i,
  output logic [DATA_W-1:0] mem_d_o,
  output logic [NB-1:0]     mem_p_o,
  output logic              mem_oe_o
);
  logic [NB-1:0] gen_par;

  slice_par_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_gen_par (
    .data_i (host_d_i),
    .par_o  (gen_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_d_o  <= '0;
      mem_p_o  <= '0;
      mem_oe_o <= 1'b0;
    end else begin
      mem_oe_o <= wr_en_i;
      if (wr_en_i) begin
        mem_d_o <= host_d_i;
        mem_p_o <= gen_par;
      end
    end
  end
endmodule

// File: rtl/slice_strap.sv
module slice_strap #(
  parameter int DATA_W  = 32,
  localparam int HALF   = DATA_W / 2,
  localparam int LANE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_hi_i,
  output logic              slice_hi_o,
  output logic [LANE_W-1:0] up_base_o,
  output logic [LANE_W-1:0] lo_base_o
);
  localparam logic [LANE_W-1:0] HALF_L = LANE_W'(HALF);
  localparam logic [LANE_W-1:0] WORD_L = LANE_W'(DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_hi_o <= strap_hi_i;
      up_base_o  <= strap_hi_i ? (WORD_L + HALF_L) : WORD_L;
      lo_base_o  <= strap_hi_i ? HALF_L : '0;
    end
  end
endmodule

// File: rtl/mem_slice_datapath.sv
module mem_slice_datapath
  import slice_dp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  localparam int NB     = DATA_W / BYTE_W,
  localparam int LANE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_hi_i,
  input  logic [CMD_W-1:0]  host_cmd_i,
  input  logic              latch_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] mem_d_i,
  input  logic [NB-1:0]     mem_p_i,
  input  logic [DATA_W-1:0] host_d_i,
  output logic [DATA_W-1:0] mem_d_o,
  output logic [NB-1:0]     mem_p_o,
  output logic              mem_oe_o,
  output logic [DATA_W-1:0] host_d_o,
  output logic [NB-1:0]     host_p_o,
  output logic              host_oe_o,
  output logic [NB-1:0]     perr_o,
  output logic              slice_hi_o,
  output logic [LANE_W-1:0] lane_up_base_o,
  output logic [LANE_W-1:0] lane_lo_base_o
);
  slice_rd_capture #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .latch_en_i (latch_en_i),
    .mem_d_i    (mem_d_i),
    .mem_p_i    (mem_p_i),
    .cap_d_o    (host_d_o),
    .cap_p_o    (host_p_o),
    .perr_o     (perr_o)
  );

  slice_host_oe u_hoe (
    .clk        (clk),
    .rst        (rst),
    .latch_en_i (latch_en_i),
    .host_cmd_i (host_cmd_i),
    .host_oe_o  (host_oe_o)
  );

  slice_wr_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .host_d_i (host_d_i),
    .mem_d_o  (mem_d_o),
    .mem_p_o  (mem_p_o),
    .mem_oe_o (mem_oe_o)
  );

  slice_strap #(.DATA_W(DATA_W)) u_strap (
    .clk        (clk),
    .rst        (rst),
    .strap_hi_i (strap_hi_i),
    .slice_hi_o (slice_hi_o),
    .up_base_o  (lane_up_base_o),
    .lo_base_o  (lane_lo_base_o)
  );
endmodule

// File: rtl/mem_slice_datapath_chk.sv
module mem_slice_datapath_chk
  import slice_dp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [CMD_W-1:0]  host_cmd_i,
  input logic              latch_en_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] mem_d_o,
  input logic [NB-1:0]     mem_p_o,
  input logic              mem_oe_o,
  input logic [DATA_W-1:0] host_d_o,
  input logic              host_oe_o,
  input logic [NB-1:0]     perr_o,
  input logic              slice_hi_o
);
  logic le_prev;
  logic [NB-1:0] exp_par;

  always_ff @(posedge clk) begin
    if (rst) le_prev <= 1'b0;
    else     le_prev <= latch_en_i;
  end

  always_comb begin
    for (int b = 0; b < NB; b++) exp_par[b] = ^mem_d_o[b*BYTE_W +: BYTE_W];
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !latch_en_i |=> $stable(host_d_o));

  assert_oe_set_R4: assert property (@(posedge clk) disable iff (rst)
    (host_cmd_i == HCMD_RDDRV) |=> host_oe_o);

  assert_oe_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (host_cmd_i == HCMD_IDLE && latch_en_i && !le_prev) |=> !host_oe_o);

  assert_oe_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (host_cmd_i != HCMD_IDLE && host_cmd_i != HCMD_RDDRV) |=> $stable(host_oe_o));

  assert_wr_par_R7: assert property (@(posedge clk) disable iff (rst)
    mem_oe_o |-> (mem_p_o == exp_par));

  assert_mem_oe_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> mem_oe_o);

  assert_perr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !latch_en_i |=> ##1 (perr_o == '0));

  assert_strap_R10: assert property (@(posedge clk) disable iff (rst)
    $stable(slice_hi_o));
endmodule

bind mem_slice_datapath mem_slice_datapath_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_cmd_i (host_cmd_i),
  .latch_en_i (latch_en_i),
  .wr_en_i    (wr_en_i),
  .mem_d_o    (mem_d_o),
  .mem_p_o    (mem_p_o),
  .mem_oe_o   (mem_oe_o),
  .host_d_o   (host_d_o),
  .host_oe_o  (host_oe_o),
  .perr_o     (perr_o),
  .slice_hi_o (slice_hi_o)
);

// File: tb/mem_slice_datapath_test.sv
module mem_slice_datapath_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_hi_i = 1'b1;
  logic [4:0]  host_cmd_i = 5'b00010;
  logic        latch_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] mem_d_i = '0;
  logic [3:0]  mem_p_i = '0;
  logic [31:0] host_d_i = '0;
  logic [31:0] mem_d_o, host_d_o;
  logic [3:0]  mem_p_o, host_p_o, perr_o;
  logic        mem_oe_o, host_oe_o, slice_hi_o;
  logic [5:0]  lane_up_base_o, lane_lo_base_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  mem_slice_datapath uut (
    .clk(clk), .rst(rst), .strap_hi_i(strap_hi_i), .host_cmd_i(host_cmd_i),
    .latch_en_i(latch_en_i), .wr_en_i(wr_en_i), .mem_d_i(mem_d_i), .mem_p_i(mem_p_i),
    .host_d_i(host_d_i), .mem_d_o(mem_d_o), .mem_p_o(mem_p_o), .mem_oe_o(mem_oe_o),
    .host_d_o(host_d_o), .host_p_o(host_p_o), .host_oe_o(host_oe_o), .perr_o(perr_o),
    .slice_hi_o(slice_hi_o), .lane_up_base_o(lane_up_base_o), .lane_lo_base_o(lane_lo_base_o)
  );

  function automatic logic [3:0] even_par(input logic [31:0] d);
    for (int b = 0; b < 4; b++) even_par[b] = ^d[b*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1; strap_hi_i = strap;
    host_cmd_i = 5'b00010; latch_en_i = 0; wr_en_i = 0;
    step(); step(); step();
    rst = 1'b0;
    chk("R1 host_oe", 64'(host_oe_o), 64'd0);
    chk("R1 mem_oe", 64'(mem_oe_o), 64'd0);
    chk("R1 perr", 64'(perr_o), 64'd0);
    chk("R1 host_d", 64'({host_d_o, host_p_o}), 64'd0);
  endtask

  task automatic t_strap();
    do_reset(1'b1);
    chk("R10 hi", 64'(slice_hi_o), 64'd1);
    chk("R10 up base", 64'(lane_up_base_o), 64'd48);
    chk("R10 lo base", 64'(lane_lo_base_o), 64'd16);
    strap_hi_i = 1'b0;
    step(); step();
    chk("R10 strap ignored", 64'({slice_hi_o, lane_up_base_o, lane_lo_base_o}), 64'({1'b1, 6'd48, 6'd16}));
    do_reset(1'b0);
    chk("R10 lo slice", 64'({slice_hi_o, lane_up_base_o, lane_lo_base_o}), 64'({1'b0, 6'd32, 6'd0}));
  endtask

  task automatic t_capture(input logic [31:0] d);
    mem_d_i = d; mem_p_i = even_par(d); latch_en_i = 1'b1;
    step();
    chk("R2 cap data", 64'(host_d_o), 64'(d));
    chk("R2 cap par", 64'(host_p_o), 64'(even_par(d)));
    latch_en_i = 1'b0; mem_d_i = ~d; mem_p_i = ~even_par(d);
    step();
    chk("R9 good parity", 64'(perr_o), 64'd0);
    chk("R3 hold", 64'({host_d_o, host_p_o}), 64'({d, even_par(d)}));
    step();
    chk("R3 hold again", 64'(host_d_o), 64'(d));
  endtask

  task automatic t_perr(input logic [31:0] d, input logic [3:0] flip);
    mem_d_i = d; mem_p_i = even_par(d) ^ flip; latch_en_i = 1'b1;
    step();
    latch_en_i = 1'b0;
    step();
    chk("R9 flags", 64'(perr_o), 64'(flip));
    step();
    chk("R9 one cycle", 64'(perr_o), 64'd0);
  endtask

  task automatic t_host_oe();
    latch_en_i = 1'b0;
    host_cmd_i = 5'b00001; step();
    chk("R4 set", 64'(host_oe_o), 64'd1);
    host_cmd_i = 5'b00111; latch_en_i = 1'b1; step();
    chk("R6 other code", 64'(host_oe_o), 64'd1);
    host_cmd_i = 5'b10000; latch_en_i = 1'b0; step();
    chk("R6 other code 2", 64'(host_oe_o), 64'd1);
    host_cmd_i = 5'b00000; step();
    chk("R5 idle no strobe", 64'(host_oe_o), 64'd1);
    latch_en_i = 1'b1; step();
    chk("R5 idle rising", 64'(host_oe_o), 64'd0);
    host_cmd_i = 5'b00001; step();
    chk("R4 set again", 64'(host_oe_o), 64'd1);
    host_cmd_i = 5'b00000; step();
    chk("R5 idle strobe held", 64'(host_oe_o), 64'd1);
    latch_en_i = 1'b0; host_cmd_i = 5'b00010; step();
  endtask

  task automatic t_write(input logic [31:0] d);
    host_d_i = d; wr_en_i = 1'b1;
    step();
    chk("R8 oe on", 64'(mem_oe_o), 64'd1);
    chk("R7 data", 64'(mem_d_o), 64'(d));
    chk("R7 parity", 64'(mem_p_o), 64'(even_par(d)));
    wr_en_i = 1'b0; host_d_i = ~d;
    step();
    chk("R8 oe off", 64'(mem_oe_o), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_strap();
    t_capture(32'hA5A5_1234);
    t_capture(32'h0000_0001);
    t_capture(32'hFFFF_FFFF);
    t_perr(32'h8001_7E03, 4'b0101);
    t_perr(32'h1234_5678, 4'b1000);
    t_perr(32'h0F0F_0F0F, 4'b1111);
    t_host_oe();
    t_write(32'h0103_FF80);
    t_write(32'h0000_0000);
    t_write(32'hDEAD_BEEF);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule